// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block brings a multi-bank EDO DRAM array out of power-up and keeps it refreshed. After reset it counts out a long quiet pause. It then runs a fixed burst of CAS-before-RAS refresh cycles on its own, with no grant needed, because no access can be in flight yet. Only after that burst does it raise `init_done`, which lets the access sequencer begin normal traffic. Each refresh relies on the DRAM's internal row counter, so no address is ever driven.

In normal operation an interval timer marks every refresh slot. Each slot adds one to a small saturating count of refreshes owed. While anything is owed, the block raises `ref_req`. The access sequencer answers with `ref_gnt` once the strobes are free. While `ref_own` is high, the scheduler drives every RAS and CAS line in lockstep: CAS falls first, then RAS, both rise together, and then a precharge follows. WE stays high the whole time. If the grant is slow, the owed refreshes are issued one after another as soon as it arrives.

All lengths are given in clock cycles and set by parameters: the pause, the burst count, the interval, the three strobe phases and the owed limit. A simulation can therefore shorten them.

Top module: `dram_refresh_sched`

## Requirements
- R1: `init_done` first goes high on exactly clock edge PAUSE_CYC + INIT_CYCLES*(T_CSR+T_RASL+T_RP) after reset is released, and once high it stays high until the next reset.
- R2: Before `init_done` rises, exactly INIT_CYCLES refresh cycles (RAS falling edges) are issued, whatever the state of `ref_gnt`.
- R3: In every refresh cycle, CAS is low for exactly T_CSR cycles with RAS high before RAS falls. CAS then stays low for every cycle in which RAS is low.
- R4: RAS stays low for exactly T_RASL cycles per refresh. Between the rise of CAS and its next fall, both strobes are high for at least T_RP cycles.
- R5: `we_n` is high (1) in every cycle, including during reset.
- R6: All NUM_BANKS bits of `ras_n` carry the same value every cycle, and so do all bits of `cas_n`.
- R7: With `ref_gnt` held high after initialization, consecutive refresh RAS falls are exactly INTERVAL_CYC cycles apart.
- R8: After initialization, a refresh starts only while `ref_gnt` is high. With no grant, `ras_n` and `cas_n` stay all ones and `ref_req` stays high while refreshes are owed.
- R9: Refresh slots that arrive while no grant is given are counted up to OWED_MAX. Once the grant arrives, that many refreshes are issued back to back. `ref_req` then falls.
- R10: `ref_req` is low (0) whenever `init_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access sequencer hands the strobes to the scheduler |
| ref_req | output | 1 | Refresh owed or in progress; asks for the strobes |
| ref_own | output | 1 | Scheduler is driving the strobe lines this cycle |
| init_done | output | 1 | Pause and initialization burst complete; access allowed |
| ras_n | output | NUM_BANKS | Row strobes, active low, all banks together |
| cas_n | output | NUM_BANKS | Column strobes, active low, all banks together |
| we_n | output | 1 | Write enable, held high for refresh |

## Verification
The bench first drives the power-up path with the grant held low. This shows that the initialization burst runs by itself, and that `init_done` rises on the edge the arithmetic predicts. With the grant held high, the spacing between refreshes tells a steady interval apart from drift or extra cycles. Withholding the grant for two refresh slots, and then for five, separates exact owed counting from saturation at the limit. A cycle-by-cycle monitor checks the strobe phase lengths, bank equality and WE against every refresh produced in all of these patterns.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
    typedef enum logic [2:0] {
        PH_PAUSE = 3'd0,
        PH_IDLE  = 3'd1,
        PH_LEAD  = 3'd2,
        PH_RASLO = 3'd3,
        PH_PRE   = 3'd4
    } ref_phase_e;
endpackage

// File: rtl/ref_slot_timer.sv
module ref_slot_timer #(
    parameter int INTERVAL_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        slot  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == TW'(INTERVAL_CYC - 1)) begin
            cnt_d = '0;
            slot  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
    parameter int OWED_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nz
);
    localparam int OW = $clog2(OWED_MAX + 1);

    logic [OW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            if (cnt_q != OW'(OWED_MAX)) cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_d = cnt_q - 1'b1;
        end
        nz = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    owed_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYC   = 10000,
    parameter int INIT_CYCLES = 8,
    parameter int T_CSR       = 1,
    parameter int T_RASL      = 3,
    parameter int T_RP        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owed_nz,
    input  logic gnt,
    output logic ras_low,
    output logic cas_low,
    output logic own,
    output logic init_done,
    output logic ref_done
);
    localparam int M1     = (T_CSR > T_RASL) ? T_CSR : T_RASL;
    localparam int M2     = (M1 > T_RP) ? M1 : T_RP;
    localparam int MAXLEN = (PAUSE_CYC > M2) ? PAUSE_CYC : M2;
    localparam int CW     = $clog2(MAXLEN + 1);
    localparam int IW     = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        ref_phase_e     phase;
        logic [CW-1:0]  cnt;
        logic [IW-1:0]  init_left;
        logic           init_done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ref_done = 1'b0;
        unique case (st_q.phase)
            PH_PAUSE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_LEAD;
                    st_d.cnt   = CW'(T_CSR - 1);
                end else st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_IDLE: begin
                if (owed_nz && gnt) begin
                    st_d.phase = PH_LEAD;
                    st_d.cnt   = CW'(T_CSR - 1);
                end
            end
            PH_LEAD: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_RASLO;
                    st_d.cnt   = CW'(T_RASL - 1);
                end else st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_RASLO: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_PRE;
                    st_d.cnt   = CW'(T_RP - 1);
                end else st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_PRE: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (st_q.init_done) begin
                    ref_done   = 1'b1;
                    st_d.phase = PH_IDLE;
                end else if (st_q.init_left == IW'(1)) begin
                    st_d.init_done = 1'b1;
                    st_d.phase     = PH_IDLE;
                end else begin
                    st_d.init_left = st_q.init_left - 1'b1;
                    st_d.phase     = PH_LEAD;
                    st_d.cnt       = CW'(T_CSR - 1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_PAUSE;
            st_q.cnt       <= CW'(PAUSE_CYC - 1);
            st_q.init_left <= IW'(INIT_CYCLES);
            st_q.init_done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cas_low   = (st_q.phase == PH_LEAD) || (st_q.phase == PH_RASLO);
    assign ras_low   = (st_q.phase == PH_RASLO);
    assign own       = cas_low || (st_q.phase == PH_PRE);
    assign init_done = st_q.init_done;

    // R3
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_low) |-> $past(cas_low));
    // R3
    cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> cas_low);
    // R4
    prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_low) |=> !ras_low);
    // R1
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int NUM_BANKS    = 4,
    parameter int PAUSE_CYC    = 10000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 780,
    parameter int OWED_MAX     = 4,
    parameter int T_CSR        = 1,
    parameter int T_RASL       = 3,
    parameter int T_RP         = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_gnt,
    output logic                 ref_req,
    output logic                 ref_own,
    output logic                 init_done,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic [NUM_BANKS-1:0] cas_n,
    output logic                 we_n
);
    logic slot, owed_nz, ras_low, cas_low, ref_done;

    ref_slot_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(init_done), .slot(slot)
    );

    ref_owed_ctr #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk(clk), .rst_n(rst_n), .inc(slot), .dec(ref_done), .nz(owed_nz)
    );

    cbr_seq #(
        .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES),
        .T_CSR(T_CSR), .T_RASL(T_RASL), .T_RP(T_RP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .gnt(ref_gnt),
        .ras_low(ras_low), .cas_low(cas_low), .own(ref_own),
        .init_done(init_done), .ref_done(ref_done)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ras_n[b] = ~ras_low;
        assign cas_n[b] = ~cas_low;
    end

    assign we_n    = 1'b1;
    assign ref_req = init_done && (owed_nz || ref_own);

    // R10
    no_req_pre_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);
    // R8
    own_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && $rose(ref_own)) |-> $past(ref_gnt));
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int NB = 4, PAUSE = 20, INIT = 8, INTV = 40, OMAX = 3;
    localparam int CSR = 1, RASL = 3, RP = 3;
    localparam int LEN = CSR + RASL + RP;

    logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
    logic req, own, idone, we;
    logic [NB-1:0] ras, cas;

    int total = 0, bad = 0, edges = 0, falls = 0, cyc = 0;
    int lead = 0, rlo = 0, pre = 0, seen_cas_fall = 0, last_fall = 0;
    logic pr_ras = 1'b1, pr_cas = 1'b1, pr_gnt = 1'b0, pr_own = 1'b0;

    dram_refresh_sched #(
        .NUM_BANKS(NB), .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT),
        .INTERVAL_CYC(INTV), .OWED_MAX(OMAX),
        .T_CSR(CSR), .T_RASL(RASL), .T_RP(RP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req),
        .ref_own(own), .init_done(idone), .ras_n(ras), .cas_n(cas), .we_n(we)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst_n) edges++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // per-cycle strobe monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras != {NB{ras[0]}} || cas != {NB{cas[0]}})
                chk(1'b0, "R6 banks differ", int'(ras), int'(cas));
            if (we !== 1'b1) chk(1'b0, "R5 we_n low", int'(we), 1);
            if (!ras[0] && cas[0]) chk(1'b0, "R3 cas high during ras low", 1, 0);
            if (idone && own && !pr_own && !pr_gnt)
                chk(1'b0, "R8 refresh without grant", 1, 0);
            if (!cas[0] && pr_cas) begin
                if (seen_cas_fall != 0) chk(pre >= RP, "R4 precharge", pre, RP);
                seen_cas_fall = 1;
            end
            if (!ras[0] && pr_ras) begin
                chk(lead == CSR, "R3 cas lead", lead, CSR);
                falls++;
                last_fall = edges;
            end
            if (ras[0] && !pr_ras) chk(rlo == RASL, "R4 ras low width", rlo, RASL);
            lead = (!cas[0] && ras[0]) ? lead + 1 : 0;
            rlo  = !ras[0] ? rlo + 1 : 0;
            pre  = (cas[0] && ras[0]) ? pre + 1 : 0;
            pr_ras = ras[0]; pr_cas = cas[0]; pr_gnt = gnt; pr_own = own;
        end
    end

    task automatic wait_edge(input int e);
        while (edges < e) @(negedge clk);
    endtask

    task automatic sync_req_rise(output int t0);
        while (req) @(negedge clk);
        while (!req) @(negedge clk);
        t0 = edges;
    endtask

    task automatic owed_case(input int k, input int expn);
        int t0, f0;
        sync_req_rise(t0);
        while (req) @(negedge clk);
        gnt = 1'b0;
        f0 = falls;
        wait_edge(t0 + k * INTV + 5);
        chk(req == 1'b1, "R8 req held while owed", int'(req), 1);
        chk(falls == f0, "R8 no refresh without grant", falls - f0, 0);
        chk(ras == '1 && cas == '1, "R8 strobes idle", int'(ras), 15);
        gnt = 1'b1;
        wait_edge(t0 + (k + 1) * INTV - 2);
        chk(falls - f0 == expn, "R9 owed refreshes issued", falls - f0, expn);
        chk(req == 1'b0, "R9 req drops after batch", int'(req), 0);
    endtask

    initial begin
        int t0, prev;
        repeat (3) @(negedge clk);
        chk(ras == '1 && cas == '1, "R6 reset strobes high", int'(ras), 15);
        chk(we == 1'b1, "R5 reset we_n", int'(we), 1);
        chk(idone == 1'b0, "R1 reset init_done", int'(idone), 0);
        chk(req == 1'b0, "R10 reset req", int'(req), 0);
        rst_n = 1'b1;
        while (!idone) begin
            @(negedge clk);
            if (!idone && req) chk(1'b0, "R10 req before init", 1, 0);
        end
        chk(edges == PAUSE + INIT * LEN, "R1 init_done edge", edges, PAUSE + INIT * LEN);
        chk(falls == INIT, "R2 init burst count", falls, INIT);
        gnt = 1'b1;
        sync_req_rise(t0);
        while (falls == INIT) @(negedge clk);
        prev = last_fall;
        for (int i = 0; i < 4; i++) begin
            int f;
            f = falls;
            while (falls == f) @(negedge clk);
            chk(last_fall - prev == INTV, "R7 refresh spacing", last_fall - prev, INTV);
            prev = last_fall;
        end
        owed_case(2, 2);
        owed_case(5, OMAX);
        chk(idone == 1'b1, "R1 init_done sticky", int'(idone), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule